// File: doc/BRIEF.md
# Transmit Handshake Sequencer

This block owns one outstanding transmit command on a token-passing network node. Software hands it a buffer page and a broadcast flag with an enable-transmit pulse. The block then drops its "transmitter available" status and waits for the node to hold the token. For a directed packet it first asks the destination whether a receive buffer is free, and then acts on the decoded reply.

An ACK starts the packet. A NAK gives the token away and keeps the command for the next visit. Silence ends the command without success. An unrecognised reply keeps the token, so no pass request is made. A broadcast packet goes straight out with no enquiry.

Two status bits report the outcome: available, and delivered-with-acknowledge. A saturating count of refused enquiries raises a sticky "too many refusals" flag. A cancel command is held until the next token arrival and then ends the command with no enquiry. Both status conditions drive interrupt lines, each gated by its own mask bit.

Top module: `tx_handshake_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_avail`=1, `tx_acked`=0, `nak_excess`=0, and the pulses `enq_send`, `pkt_send` and `tok_pass` are 0.
- R2: `cmd_tx_en` is accepted only while `tx_avail`=1. Acceptance clears `tx_avail` and `tx_acked` and latches `cmd_page` into `cur_page` in the next cycle. While `tx_avail`=0 the command is ignored and `cur_page` keeps its value.
- R3: With a command pending, a `token_here` pulse gives a one-cycle pulse in the next cycle. That pulse is `enq_send` for a directed packet (`cmd_bcast`=0 at acceptance) and `pkt_send` for a broadcast.
- R4: After an enquiry, a reply with `reply_kind`=2'b00 (ACK) gives a `pkt_send` pulse. A following `pkt_done` gives a `tok_pass` pulse and sets `tx_avail`=1 and `tx_acked`=`pkt_ack`.
- R5: A reply with `reply_kind`=2'b01 (NAK) gives a `tok_pass` pulse and keeps the command pending (`tx_avail`=0). The next `token_here` sends the enquiry again.
- R6: The NAK_LIMIT-th NAK of one command sets `nak_excess` in the cycle after that reply. The flag stays set until the next accepted `cmd_tx_en` clears it.
- R7: `reply_tmo` with no reply while waiting gives a `tok_pass` pulse and sets `tx_avail`=1 with `tx_acked`=0.
- R8: A reply with `reply_kind`=2'b10 or 2'b11 (unrecognised) gives no `tok_pass` pulse and keeps the command pending. The next `token_here` sends the enquiry again.
- R9: `cmd_tx_dis` while a command is pending changes nothing until the next `token_here`. That token arrival gives a `tok_pass` pulse and no enquiry, and sets `tx_avail`=1 with `tx_acked`=0. `cmd_tx_dis` while `tx_avail`=1 has no effect.
- R10: `irq_avail` equals `tx_avail & irq_mask[0]`, and `irq_excess` equals `nak_excess & irq_mask[1]`, each one cycle after its inputs.
- R11: A broadcast completes on `pkt_done` with `tx_avail`=1 and `tx_acked`=0, whatever the value of `pkt_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_tx_en | input | 1 | Enable-transmit command pulse |
| cmd_page | input | PAGE_W | Buffer page of the command |
| cmd_bcast | input | 1 | Command is a broadcast |
| cmd_tx_dis | input | 1 | Disable-transmitter command pulse |
| token_here | input | 1 | Token arrival pulse |
| reply_valid | input | 1 | A decoded reply is present |
| reply_kind | input | 2 | 00 ACK, 01 NAK, 10/11 unrecognised |
| reply_tmo | input | 1 | Reply wait timed out |
| pkt_done | input | 1 | Packet transmission finished |
| pkt_ack | input | 1 | Finished packet was acknowledged |
| irq_mask | input | 2 | Bit 0 avail interrupt, bit 1 excess interrupt |
| tx_avail | output | 1 | Transmitter available status |
| tx_acked | output | 1 | Last packet acknowledged status |
| nak_excess | output | 1 | Refusal limit reached |
| cur_page | output | PAGE_W | Page of the current command |
| enq_send | output | 1 | Request to send a free-buffer enquiry |
| pkt_send | output | 1 | Request to send the packet |
| tok_pass | output | 1 | Request to pass the token |
| irq_avail | output | 1 | Masked available interrupt |
| irq_excess | output | 1 | Masked refusal-limit interrupt |

## Verification
Status bits, `cur_page` and the three request pulses are registered, so each is due one clock after the edge that samples its stimulus. The interrupt lines are registered again and are due two clocks after the stimulus. The bench drives every input on a falling edge and clears it on the next falling edge. It reads status at that second falling edge, and waits one more falling edge before reading the interrupt lines. A monitor checks every request pulse at each falling edge against a queue of expected pulses that the driver fills.

// File: rtl/txh_pkg.sv
package txh_pkg;
  typedef enum logic [1:0] {
    RPL_ACK   = 2'b00,
    RPL_NAK   = 2'b01,
    RPL_JUNKA = 2'b10,
    RPL_JUNKB = 2'b11
  } reply_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_TOKEN,
    ST_WAIT_REPLY,
    ST_SENDING
  } state_e;
endpackage

// File: rtl/txh_nak_counter.sv
module txh_nak_counter #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (inc && cnt_q != LIM) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      hit   <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (cnt_nx == LIM) hit <= 1'b1;
    end
  end

  // R6: sticky until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (hit && !clr) |=> hit);
  // R6: count never passes the limit
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);
endmodule

// File: rtl/txh_irq_gate.sv
module txh_irq_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= src[i] & mask[i];
    end

    // R10: a line is high only if source and mask were high a cycle earlier
    a_r10_gated: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(src[i] & mask[i]));
  end
endmodule

// File: rtl/tx_handshake_seq.sv
module tx_handshake_seq
  import txh_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int NAK_LIMIT = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_tx_en,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              cmd_bcast,
  input  logic              cmd_tx_dis,
  input  logic              token_here,
  input  logic              reply_valid,
  input  logic [1:0]        reply_kind,
  input  logic              reply_tmo,
  input  logic              pkt_done,
  input  logic              pkt_ack,
  input  logic [1:0]        irq_mask,
  output logic              tx_avail,
  output logic              tx_acked,
  output logic              nak_excess,
  output logic [PAGE_W-1:0] cur_page,
  output logic              enq_send,
  output logic              pkt_send,
  output logic              tok_pass,
  output logic              irq_avail,
  output logic              irq_excess
);
  state_e state_q;
  logic   bcast_q;
  logic   dis_pend_q;
  reply_e rk;
  logic   nak_inc;
  logic   nak_clr;
  logic [1:0] irq_vec;

  assign rk      = reply_e'(reply_kind);
  assign nak_inc = (state_q == ST_WAIT_REPLY) && reply_valid && (rk == RPL_NAK);
  assign nak_clr = (state_q == ST_IDLE) && cmd_tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tx_avail   <= 1'b1;
      tx_acked   <= 1'b0;
      cur_page   <= '0;
      bcast_q    <= 1'b0;
      dis_pend_q <= 1'b0;
      enq_send   <= 1'b0;
      pkt_send   <= 1'b0;
      tok_pass   <= 1'b0;
    end else begin
      enq_send <= 1'b0;
      pkt_send <= 1'b0;
      tok_pass <= 1'b0;
      if (cmd_tx_dis && !tx_avail) dis_pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_tx_en) begin
            tx_avail   <= 1'b0;
            tx_acked   <= 1'b0;
            cur_page   <= cmd_page;
            bcast_q    <= cmd_bcast;
            dis_pend_q <= 1'b0;
            state_q    <= ST_WAIT_TOKEN;
          end
        end
        ST_WAIT_TOKEN: begin
          if (token_here) begin
            if (dis_pend_q) begin
              tx_avail   <= 1'b1;
              tok_pass   <= 1'b1;
              dis_pend_q <= 1'b0;
              state_q    <= ST_IDLE;
            end else if (bcast_q) begin
              pkt_send <= 1'b1;
              state_q  <= ST_SENDING;
            end else begin
              enq_send <= 1'b1;
              state_q  <= ST_WAIT_REPLY;
            end
          end
        end
        ST_WAIT_REPLY: begin
          if (reply_valid) begin
            unique case (rk)
              RPL_ACK: begin
                pkt_send <= 1'b1;
                state_q  <= ST_SENDING;
              end
              RPL_NAK: begin
                tok_pass <= 1'b1;
                state_q  <= ST_WAIT_TOKEN;
              end
              default: state_q <= ST_WAIT_TOKEN;
            endcase
          end else if (reply_tmo) begin
            tx_avail   <= 1'b1;
            tok_pass   <= 1'b1;
            dis_pend_q <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        ST_SENDING: begin
          if (pkt_done) begin
            tx_avail   <= 1'b1;
            tx_acked   <= pkt_ack && !bcast_q;
            tok_pass   <= 1'b1;
            dis_pend_q <= 1'b0;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  txh_nak_counter #(.LIMIT(NAK_LIMIT)) u_nak (
    .clk (clk),
    .rst (rst),
    .clr (nak_clr),
    .inc (nak_inc),
    .hit (nak_excess)
  );

  txh_irq_gate #(.N(2)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .src  ({nak_excess, tx_avail}),
    .mask (irq_mask),
    .irq  (irq_vec)
  );
  assign irq_avail  = irq_vec[0];
  assign irq_excess = irq_vec[1];

  // R2: an accepted command clears both status bits
  a_r2_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_tx_en && tx_avail) |=> (!tx_avail && !tx_acked));
  // R3: an enquiry only follows a token arrival
  a_r3_enq_on_token: assert property (@(posedge clk) disable iff (rst)
    enq_send |-> $past(token_here));
  // R4: acknowledged implies available
  a_r4_ack_needs_avail: assert property (@(posedge clk) disable iff (rst)
    tx_acked |-> tx_avail);
  // R7: every completion also passes the token
  a_r7_done_passes: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_avail) |-> tok_pass);
  // R8: unrecognised reply never passes the token
  a_r8_junk_keeps: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_REPLY && reply_valid && reply_kind[1]) |=> !tok_pass);
  // R9: a held cancel ends the command at the token with no enquiry
  a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_TOKEN && token_here && dis_pend_q)
      |=> (tx_avail && !tx_acked && !enq_send));
endmodule

// File: tb/sim_tx_handshake_seq.sv
module sim_tx_handshake_seq;
  localparam int PW  = 4;
  localparam int LIM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_tx_en = 0, cmd_bcast = 0, cmd_tx_dis = 0, token_here = 0;
  logic reply_valid = 0, reply_tmo = 0, pkt_done = 0, pkt_ack = 0;
  logic [1:0] reply_kind = 2'b00;
  logic [1:0] irq_mask = 2'b11;
  logic [PW-1:0] cmd_page = '0;
  logic tx_avail, tx_acked, nak_excess, enq_send, pkt_send, tok_pass;
  logic irq_avail, irq_excess;
  logic [PW-1:0] cur_page;

  int checks = 0, fails = 0;
  logic [2:0] expq[$];   // {tok_pass, pkt_send, enq_send}

  always #10 clk = ~clk;

  tx_handshake_seq #(.PAGE_W(PW), .NAK_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .cmd_tx_en(cmd_tx_en), .cmd_page(cmd_page),
    .cmd_bcast(cmd_bcast), .cmd_tx_dis(cmd_tx_dis), .token_here(token_here),
    .reply_valid(reply_valid), .reply_kind(reply_kind), .reply_tmo(reply_tmo),
    .pkt_done(pkt_done), .pkt_ack(pkt_ack), .irq_mask(irq_mask),
    .tx_avail(tx_avail), .tx_acked(tx_acked), .nak_excess(nak_excess),
    .cur_page(cur_page), .enq_send(enq_send), .pkt_send(pkt_send),
    .tok_pass(tok_pass), .irq_avail(irq_avail), .irq_excess(irq_excess));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every request pulse must match the queue front
  always @(negedge clk) begin
    if (!rst && {tok_pass, pkt_send, enq_send} != 3'b000) begin
      if (expq.size() == 0) chk("R3-R9 pulse", {5'b0, tok_pass, pkt_send, enq_send}, 8'h00);
      else chk("R3-R9 pulse", {5'b0, tok_pass, pkt_send, enq_send}, {5'b0, expq.pop_front()});
    end
  end

  task automatic expect_pulse(input logic [2:0] e);
    if (e != 3'b000) expq.push_back(e);
  endtask

  task automatic enable(input logic [PW-1:0] pg, input logic bc);
    @(negedge clk); cmd_tx_en = 1; cmd_page = pg; cmd_bcast = bc;
    @(negedge clk); cmd_tx_en = 0;
  endtask
  task automatic token(input logic [2:0] e);
    expect_pulse(e);
    @(negedge clk); token_here = 1;
    @(negedge clk); token_here = 0;
  endtask
  task automatic reply(input logic [1:0] k, input logic [2:0] e);
    expect_pulse(e);
    @(negedge clk); reply_valid = 1; reply_kind = k;
    @(negedge clk); reply_valid = 0;
  endtask
  task automatic done(input logic a);
    expect_pulse(3'b100);
    @(negedge clk); pkt_done = 1; pkt_ack = a;
    @(negedge clk); pkt_done = 0;
  endtask
  task automatic timeout();
    expect_pulse(3'b100);
    @(negedge clk); reply_tmo = 1;
    @(negedge clk); reply_tmo = 0;
  endtask
  task automatic disable_tx();
    @(negedge clk); cmd_tx_dis = 1;
    @(negedge clk); cmd_tx_dis = 0;
  endtask
  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset status", {5'b0, tx_avail, tx_acked, nak_excess}, 8'b100);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {5'b0, tx_avail, tx_acked, nak_excess}, 8'b100);
    chk("R10 irq_avail masked on", {7'b0, irq_avail}, 8'h1);

    enable(4'd5, 1'b0);
    chk("R2 accept clears", {6'b0, tx_avail, tx_acked}, 8'h0);
    chk("R2 page latched", {4'b0, cur_page}, 8'h5);
    enable(4'd9, 1'b0);
    chk("R2 ignored when busy", {4'b0, cur_page}, 8'h5);
    token(3'b001);                          // R3 enquiry
    reply(2'b00, 3'b010);                   // R4 ACK starts packet
    done(1'b1);
    chk("R4 acked completion", {6'b0, tx_avail, tx_acked}, 8'h3);

    enable(4'd2, 1'b0);
    token(3'b001);
    reply(2'b00, 3'b010);
    done(1'b0);
    chk("R4 unacked completion", {6'b0, tx_avail, tx_acked}, 8'h2);

    enable(4'd3, 1'b0);
    token(3'b001);
    reply(2'b01, 3'b100);                   // R5 NAK passes token
    chk("R5 still pending", {7'b0, tx_avail}, 8'h0);
    token(3'b001);                          // R5 enquiry repeated
    reply(2'b10, 3'b000);                   // R8 junk, no pass
    chk("R8 still pending", {7'b0, tx_avail}, 8'h0);
    token(3'b001);
    reply(2'b11, 3'b000);
    token(3'b001);
    timeout();
    chk("R7 timeout status", {6'b0, tx_avail, tx_acked}, 8'h2);

    enable(4'd7, 1'b0);
    for (int i = 1; i <= LIM; i++) begin
      token(3'b001);
      reply(2'b01, 3'b100);
      chk("R6 excess flag", {7'b0, nak_excess}, (i == LIM) ? 8'h1 : 8'h0);
    end
    @(negedge clk);
    chk("R10 irq_excess masked on", {7'b0, irq_excess}, 8'h1);
    irq_mask = 2'b01;
    @(negedge clk); @(negedge clk);
    chk("R10 irq_excess masked off", {7'b0, irq_excess}, 8'h0);
    disable_tx();
    chk("R9 cancel deferred", {7'b0, tx_avail}, 8'h0);
    token(3'b100);
    chk("R9 cancel at token", {6'b0, tx_avail, tx_acked}, 8'h2);
    chk("R6 flag held", {7'b0, nak_excess}, 8'h1);

    enable(4'd1, 1'b1);
    chk("R6 flag cleared by enable", {7'b0, nak_excess}, 8'h0);
    @(negedge clk);
    chk("R10 irq_avail drops", {7'b0, irq_avail}, 8'h0);
    token(3'b010);                          // R3 broadcast sends directly
    done(1'b1);
    chk("R11 broadcast completion", {6'b0, tx_avail, tx_acked}, 8'h2);

    disable_tx();                           // R9 ignored while available
    enable(4'd4, 1'b0);
    token(3'b001);
    chk("R9 idle cancel ignored", {7'b0, tx_avail}, 8'h0);
    timeout();
    repeat (3) @(negedge clk);
    chk("R3 no missing pulses", 8'(expq.size()), 8'h0);
    summary();
  end
endmodule